// File: doc/BRIEF.md
# Receive FIFO threshold controller

This block is the receive-side buffer between a network MAC and a reader that moves frames into memory. Words arrive from the MAC with an end-of-frame marker. They are held in a word-wide FIFO and leave on a first-word-fall-through read stream. The block keeps a running fill level and a count of complete frames stored. It compares the fill level against four programmable thresholds to decide three things: when the reader may start taking data, when reading must pause inside a frame, and when an arriving frame must be cut short to protect the FIFO.

Two release policies share the same hardware. A nonzero release threshold gives cut-through: data is offered once enough words are buffered, and a hysteresis band keeps the offer alive. Reading stalls at the stall threshold while the frame's end is still missing. A zero release threshold gives store-and-forward: data is offered only while at least one whole frame is buffered. The same fill level also drives pause requests to the transmit side. An XOFF request goes out when the level climbs to the pause threshold, and an XON request goes out when it falls back below it.

The write stream cannot be back-pressured, so `in_ready` stays high. When space runs short, the block truncates the frame instead of stalling the MAC. The read stream follows valid/ready rules: a word transfers on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high, the head word stays on `out_data`/`out_last`/`out_err` until it is taken.

Top module: `rxq_flow_ctrl`

## Requirements
- R1: After reset the FIFO is empty, and `data_avail`, `out_valid` and `pause_req` are low.
- R2: With a nonzero release threshold, `data_avail` is high whenever the fill level is at least that threshold.
- R3: `data_avail` is high whenever at least one complete frame (a word stored with `out_last` set) is in the FIFO, in either release mode.
- R4: With a release threshold of 0 (store-and-forward), `data_avail` is high only while at least one complete frame is stored.
- R5: With a nonzero release threshold, `data_avail` stays high once raised. It drops only when no complete frame is stored and the level is zero or below the stall threshold.
- R6: `out_valid` is high only when `data_avail` is high, the FIFO is not empty, and either a complete frame is stored or the level exceeds the stall threshold. Reading therefore halts at the stall threshold inside an unfinished frame.
- R7: Words leave in write order with their data and end-of-frame flag unchanged. The head word is presented before it is taken.
- R8: Let free space be the depth minus the level. A word that arrives in a frame being passed while free space is at or below the guard threshold is handled in one of two ways. If free space is nonzero, the word is stored with end-of-frame and error both set (`out_err` = 1). If free space is zero, the word is dropped. Either way, later words of that frame are dropped up to and including its end-of-frame. The FIFO never overflows, and untruncated words carry `out_err` = 0.
- R9: With a nonzero pause threshold, `pause_req` pulses for one cycle with `pause_xoff` = 1 on the cycle after a cycle where the level is at or above the threshold and no XOFF is outstanding. No second XOFF is issued before an XON.
- R10: While an XOFF is outstanding, `pause_req` pulses with `pause_xoff` = 0 on the cycle after a cycle where the level is below the pause threshold. That XON clears the outstanding state.
- R11: A pause threshold of 0 suppresses all pause requests and clears any outstanding XOFF without sending an XON.
- R12: `in_ready` is always high; the write side is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write word present |
| in_ready | output | 1 | Always high |
| in_data | input | DATA_W | Write word |
| in_last | input | 1 | Write word ends its frame |
| out_valid | output | 1 | Head word offered to the reader |
| out_ready | input | 1 | Reader takes the head word |
| out_data | output | DATA_W | Head word data |
| out_last | output | 1 | Head word ends its frame |
| out_err | output | 1 | Head word ends a truncated frame |
| thr_pause_lvl | input | LVL_W | Level for XOFF/XON; 0 disables pause requests |
| thr_release_lvl | input | LVL_W | Cut-through release level; 0 selects store-and-forward |
| thr_stall_lvl | input | LVL_W | Level at which reading halts inside an unfinished frame |
| thr_guard_free | input | LVL_W | Free-space limit that triggers truncation |
| data_avail | output | 1 | Data may be read |
| pause_req | output | 1 | One-cycle pause frame request |
| pause_xoff | output | 1 | Request type: 1 = XOFF, 0 = XON |

## Verification
The assertions rely on a few conditions on the inputs. The thresholds must hold still outside reset. A nonzero release threshold must exceed the stall threshold. The guard threshold must be at least 1, so that a truncating word always finds a free slot before the FIFO fills. The bench meets these conditions by fixing one threshold set per sweep point and resetting between points. It draws release levels only from 0 or values above every stall level it uses, and guard values of 1 or more. Traffic is pseudo-random frames of 1 to 12 words. The reader is first slowed so that the level reaches truncation, then sped up, then left to drain.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Ingress handling of the frame currently arriving
  typedef enum logic {
    ING_PASS = 1'b0,  // words are stored
    ING_DROP = 1'b1   // frame was truncated; discard until its end
  } ing_mode_e;
endpackage

// File: rtl/rxq_ingress.sv
module rxq_ingress
  import rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  thr_guard_free,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_last,
  output logic              push_err
);
  ing_mode_e        mode_q, mode_d;
  logic [LVL_W-1:0] free_slots;
  logic             room_ok;

  assign free_slots = LVL_W'(DEPTH) - level;
  assign room_ok    = free_slots > thr_guard_free;
  assign push_data  = in_data;

  always_comb begin
    push      = 1'b0;
    push_last = in_last;
    push_err  = 1'b0;
    mode_d    = mode_q;
    if (in_valid) begin
      unique case (mode_q)
        ING_PASS: begin
          if (room_ok) begin
            push = 1'b1;
          end else begin
            // cut the frame: close it with an error-marked word if a slot exists
            push      = (free_slots != '0);
            push_last = 1'b1;
            push_err  = 1'b1;
            if (!in_last) mode_d = ING_DROP;
          end
        end
        ING_DROP: begin
          if (in_last) mode_d = ING_PASS;
        end
        default: mode_d = ING_PASS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= ING_PASS;
    else        mode_q <= mode_d;
  end

  assert_trunc_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_err) |-> push_last);
  assert_drop_stores_nothing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ING_DROP) |-> !push);
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_last,
  input  logic              push_err,
  input  logic              pop,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  frames,
  output logic [DATA_W-1:0] head_data,
  output logic              head_last,
  output logic              head_err
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level_q, frames_q;
  logic [WORD_W-1:0] head_word;
  logic              fr_inc, fr_dec;

  assign head_word = mem[rd_ptr];
  assign head_data = head_word[DATA_W-1:0];
  assign head_last = head_word[DATA_W];
  assign head_err  = head_word[DATA_W+1];
  assign level     = level_q;
  assign frames    = frames_q;
  assign fr_inc    = push && push_last;
  assign fr_dec    = pop && head_last;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_err, push_last, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level_q  <= '0;
      frames_q <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      level_q  <= level_q + {{(LVL_W-1){1'b0}}, push} - {{(LVL_W-1){1'b0}}, pop};
      frames_q <= frames_q + {{(LVL_W-1){1'b0}}, fr_inc} - {{(LVL_W-1){1'b0}}, fr_dec};
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level_q != LVL_W'(DEPTH)));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level_q != '0));
  assert_frames_within_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frames_q <= level_q);
endmodule

// File: rtl/rxq_release.sv
module rxq_release #(
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] frames,
  input  logic [LVL_W-1:0] thr_release_lvl,
  input  logic [LVL_W-1:0] thr_stall_lvl,
  input  logic             out_ready,
  output logic             data_avail,
  output logic             out_valid,
  output logic             pop
);
  logic cut_through, have_frame, held_q;

  assign cut_through = (thr_release_lvl != '0);
  assign have_frame  = (frames != '0);

  // raise on a whole frame or the release level; hold down to the stall level
  assign data_avail = have_frame
                   || (cut_through && level >= thr_release_lvl)
                   || (cut_through && held_q && level != '0 && level >= thr_stall_lvl);

  // inside an unfinished frame, keep more than the stall level buffered
  assign out_valid = data_avail && (level != '0) && (have_frame || level > thr_stall_lvl);
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= data_avail;
  end

  assert_saf_whole_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cut_through && data_avail) |-> have_frame);
  assert_stall_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !have_frame) |-> (level > thr_stall_lvl));
  assert_release_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_through && level >= thr_release_lvl) |-> data_avail);
endmodule

// File: rtl/rxq_pause.sv
module rxq_pause #(
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr_pause_lvl,
  output logic             pause_req,
  output logic             pause_xoff
);
  logic enabled, congested, xoff_out_q;

  assign enabled   = (thr_pause_lvl != '0);
  assign congested = (level >= thr_pause_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff_out_q <= 1'b0;
      pause_req  <= 1'b0;
      pause_xoff <= 1'b0;
    end else if (!enabled) begin
      xoff_out_q <= 1'b0;
      pause_req  <= 1'b0;
    end else if (!xoff_out_q && congested) begin
      xoff_out_q <= 1'b1;
      pause_req  <= 1'b1;
      pause_xoff <= 1'b1;
    end else if (xoff_out_q && !congested) begin
      xoff_out_q <= 1'b0;
      pause_req  <= 1'b1;
      pause_xoff <= 1'b0;
    end else begin
      pause_req  <= 1'b0;
    end
  end

  assert_no_double_xoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && pause_xoff) |=> !(pause_req && pause_xoff));
  assert_disabled_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !pause_req);
  assert_xon_after_xoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_xoff) |-> !xoff_out_q);
endmodule

// File: rtl/rxq_flow_ctrl.sv
module rxq_flow_ctrl #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              out_err,
  input  logic [LVL_W-1:0]  thr_pause_lvl,
  input  logic [LVL_W-1:0]  thr_release_lvl,
  input  logic [LVL_W-1:0]  thr_stall_lvl,
  input  logic [LVL_W-1:0]  thr_guard_free,
  output logic              data_avail,
  output logic              pause_req,
  output logic              pause_xoff
);
  logic              push, push_last, push_err, pop;
  logic [DATA_W-1:0] push_data;
  logic [LVL_W-1:0]  level, frames;

  assign in_ready = 1'b1;

  rxq_ingress #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ingress_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .level(level), .thr_guard_free(thr_guard_free),
    .push(push), .push_data(push_data), .push_last(push_last), .push_err(push_err)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(push_data), .push_last(push_last), .push_err(push_err),
    .pop(pop), .level(level), .frames(frames),
    .head_data(out_data), .head_last(out_last), .head_err(out_err)
  );

  rxq_release #(.DEPTH(DEPTH)) release_i (
    .clk(clk), .rst_n(rst_n),
    .level(level), .frames(frames),
    .thr_release_lvl(thr_release_lvl), .thr_stall_lvl(thr_stall_lvl),
    .out_ready(out_ready),
    .data_avail(data_avail), .out_valid(out_valid), .pop(pop)
  );

  rxq_pause #(.DEPTH(DEPTH)) pause_i (
    .clk(clk), .rst_n(rst_n),
    .level(level), .thr_pause_lvl(thr_pause_lvl),
    .pause_req(pause_req), .pause_xoff(pause_xoff)
  );

  assert_head_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_last)));
endmodule

// File: tb/rxq_flow_ctrl_tb_top.sv
module rxq_flow_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int D  = 16;
  localparam int LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, out_last, out_err, data_avail, pause_req, pause_xoff;
  logic [DW-1:0] out_data;
  logic [LW-1:0] thr_pause_lvl = '0, thr_release_lvl = '0, thr_stall_lvl = '0, thr_guard_free = '0;

  rxq_flow_ctrl #(.DATA_W(DW), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_err(out_err),
    .thr_pause_lvl(thr_pause_lvl), .thr_release_lvl(thr_release_lvl),
    .thr_stall_lvl(thr_stall_lvl), .thr_guard_free(thr_guard_free),
    .data_avail(data_avail), .pause_req(pause_req), .pause_xoff(pause_xoff)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // reference state derived from the requirements
  logic [DW+1:0] mq[$];
  int  m_frames;
  bit  m_held, m_drop, m_xout, m_req, m_xoff;

  task automatic run_config(input int se, input int sf, input int ae, input int af);
    int rem = 0;
    int wcount = 0;
    thr_pause_lvl   = LW'(se);
    thr_release_lvl = LW'(sf);
    thr_stall_lvl   = LW'(ae);
    thr_guard_free  = LW'(af);
    in_valid = 1'b0; out_ready = 1'b0;
    rst_n = 1'b0;
    mq.delete();
    m_frames = 0; m_held = 0; m_drop = 0; m_xout = 0; m_req = 0; m_xoff = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(data_avail == 1'b0, "R1 data_avail after reset", int'(data_avail), 0);
    chk(out_valid  == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(pause_req  == 1'b0, "R1 pause_req after reset", int'(pause_req), 0);
    for (int cyc = 0; cyc < 400; cyc++) begin
      int  lvl;
      bit  cut, e_av, e_ov, do_pop, do_push, w_last, w_err, v, rdy;
      int  rd_rate;
      lvl = mq.size();
      cut = (sf != 0);
      e_av = (m_frames != 0) || (cut && lvl >= sf) || (cut && m_held && lvl != 0 && lvl >= ae);
      e_ov = e_av && lvl != 0 && (m_frames != 0 || lvl > ae);
      if (m_frames != 0)   chk(data_avail == e_av, "R3 data_avail", int'(data_avail), int'(e_av));
      else if (!cut)       chk(data_avail == e_av, "R4 data_avail", int'(data_avail), int'(e_av));
      else if (lvl >= sf)  chk(data_avail == e_av, "R2 data_avail", int'(data_avail), int'(e_av));
      else                 chk(data_avail == e_av, "R5 data_avail", int'(data_avail), int'(e_av));
      chk(out_valid == e_ov, "R6 out_valid", int'(out_valid), int'(e_ov));
      chk(in_ready == 1'b1, "R12 in_ready", int'(in_ready), 1);
      if (se == 0)
        chk(pause_req == 1'b0, "R11 pause_req", int'(pause_req), 0);
      else begin
        chk(pause_req == m_req, "R9 pause_req", int'(pause_req), int'(m_req));
        if (m_req && m_xoff)  chk(pause_xoff == 1'b1, "R9 pause_xoff", int'(pause_xoff), 1);
        if (m_req && !m_xoff) chk(pause_xoff == 1'b0, "R10 pause_xoff", int'(pause_xoff), 0);
      end
      if (e_ov && out_valid) begin
        chk(out_data == mq[0][DW-1:0], "R7 out_data", int'(out_data), int'(mq[0][DW-1:0]));
        chk(out_last == mq[0][DW], "R7 out_last", int'(out_last), int'(mq[0][DW]));
        chk(out_err == mq[0][DW+1], "R8 out_err", int'(out_err), int'(mq[0][DW+1]));
      end
      // choose inputs: slow reader, fast reader, then drain
      rd_rate = (cyc < 150) ? 1 : 7;
      rdy = (cyc >= 320) ? 1'b1 : ((rnd() % 8) < rd_rate);
      v   = (cyc < 300) && ((rnd() % 4) != 0);
      if (v && rem == 0) rem = int'(rnd() % 12) + 1;
      w_last = v && (rem == 1);
      out_ready = rdy;
      in_valid  = v;
      in_last   = w_last;
      in_data   = DW'(wcount);
      // model next state
      do_pop = e_ov && rdy;
      do_push = 1'b0; w_err = 1'b0;
      if (v) begin
        rem--;
        wcount++;
        if (m_drop) begin
          if (w_last) m_drop = 0;
        end else if ((D - lvl) > af) begin
          do_push = 1'b1;
        end else begin
          do_push = (D - lvl) != 0;
          w_err = 1'b1;
          w_last = 1'b1;
          if (!in_last) m_drop = 1;
        end
      end
      @(posedge clk);
      if (do_pop) begin
        if (mq[0][DW]) m_frames--;
        void'(mq.pop_front());
      end
      if (do_push) begin
        mq.push_back({w_err, w_last, in_data});
        if (w_last) m_frames++;
      end
      m_held = e_av;
      if (se == 0) begin
        m_xout = 0; m_req = 0;
      end else if (!m_xout && lvl >= se) begin
        m_xout = 1; m_req = 1; m_xoff = 1;
      end else if (m_xout && lvl < se) begin
        m_xout = 0; m_req = 1; m_xoff = 0;
      end else m_req = 0;
      @(negedge clk);
      chk(mq.size() <= D, "R8 no overflow", mq.size(), D);
    end
  endtask

  initial begin
    int se_tab[3] = '{0, 4, 10};
    int sf_tab[3] = '{0, 5, 9};
    int ae_tab[2] = '{1, 3};
    int af_tab[2] = '{1, 3};
    foreach (se_tab[a]) foreach (sf_tab[b]) foreach (ae_tab[c]) foreach (af_tab[d])
      run_config(se_tab[a], sf_tab[b], ae_tab[c], af_tab[d]);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule